// File: doc/BRIEF.md
# In-Order Split-ALU Packed Logic Pipeline

This block is a single-issue execution pipe for 64-bit packed bitwise instructions. Instructions arrive already decoded at an issue port with a valid/ready handshake. Each names a destination register, a source register and one of four logic operations, and computes `dst = dst op src` on an eight-entry register file. An instruction travels through four front stages: scheduler entry, a rename placeholder, issue select and register read. It then passes through an ALU that is cut into two stages. The low half of the lanes is computed in the first ALU stage and the high half in the second.

The full result exists only at the end of the second ALU stage. That stage's output is written to the register file and, in the same cycle, forwarded to the operands that the register-read stage hands on. An instruction that reads the result of the instruction directly ahead of it waits one extra cycle in register read, and one empty slot is placed in the first ALU stage. Independent instructions flow through at one per cycle. Instructions issue and retire strictly in program order. A retire port shows each finished instruction's destination and result.

Top module: `simd_logic_pipe`

## Requirements
- R1: While reset is held and after it is released, `ret_valid` is low and `iss_ready` is high. Register i resets to `RESET_SEED` rotated left by (8*i mod DATA_W) bits.
- R2: The operation code selects the function: 2'b00 is dst AND src, 2'b01 is dst XOR src, 2'b10 is (NOT dst) AND src, 2'b11 is dst OR src. The result is written back to register dst.
- R3: An instruction accepted at clock edge n shows `ret_valid` high after edge n+5 when nothing ahead of it stalls. This is the sixth cycle, counting the cycle in the first stage as cycle 1.
- R4: Independent instructions issued back to back retire one per cycle. Four such instructions finish on cycles 6, 7, 8 and 9.
- R5: Instructions retire in the order they were accepted.
- R6: An instruction that names the destination of the instruction directly ahead of it, as its own dst or as its src, retires exactly one cycle later than it otherwise would. One independent instruction followed by a chain of three dependent ones finishes on cycle 11 instead of 9.
- R7: An instruction that depends on the instruction two places ahead of it suffers no delay and receives that instruction's result.
- R8: During a stall cycle `iss_ready` is low and every stage from register read upward holds its contents. In a sequence of a producer, a dependent instruction and four independent ones issued back to back, the last one is accepted six edges after the producer instead of five.
- R9: During each retire cycle, `ret_dst` carries the destination index of the retiring instruction and `ret_data` carries its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered at the issue port |
| iss_ready | output | 1 | The pipe accepts the offered instruction at this edge |
| iss_op | input | 2 | Operation code (see R2) |
| iss_dst | input | AW (3) | Destination register, also the first operand |
| iss_src | input | AW (3) | Source register, the second operand |
| ret_valid | output | 1 | An instruction completes this cycle |
| ret_dst | output | AW (3) | Destination index of the completing instruction |
| ret_data | output | DATA_W (64) | Result of the completing instruction |

## Verification
The bench uses the default parameters. With DATA_W of 64 and LANE_W of 8, there are eight lanes, four in each ALU stage, so a fault in either half or in the forwarding of the second half shows up in the result data. The eight registers with rotated seed values start with distinct contents, so every operation and every wrong operand selection gives a value the reference model can tell apart. The three-bit register index leaves room for chains on one register, dependences through the source operand, and dependences at distance two.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [1:0] {
      OP_AND  = 2'b00,
      OP_XOR  = 2'b01,
      OP_ANDN = 2'b10,
      OP_OR   = 2'b11
   } slp_op_e;

endpackage

// File: rtl/slp_logic_lane.sv
module slp_logic_lane
   import slp_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   always_comb begin
      unique case (slp_op_e'(op))
         OP_AND:  y = a & b;
         OP_XOR:  y = a ^ b;
         OP_ANDN: y = ~a & b;
         default: y = a | b;
      endcase
   end

endmodule

// File: rtl/slp_regfile.sv
module slp_regfile #(
   parameter int                DATA_W     = 64,
   parameter int                NREGS      = 8,
   parameter int                AW         = 3,
   parameter logic [DATA_W-1:0] RESET_SEED = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [AW-1:0]     ra0,
   output logic [DATA_W-1:0] rd0,
   input  logic [AW-1:0]     ra1,
   output logic [DATA_W-1:0] rd1
);

   logic [DATA_W-1:0] mem [NREGS];

   function automatic logic [DATA_W-1:0] seed_rot(input int idx);
      int sh;
      sh = (8 * idx) % DATA_W;
      if (sh == 0) return RESET_SEED;
      return (RESET_SEED << sh) | (RESET_SEED >> (DATA_W - sh));
   endfunction

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREGS; i++) begin
         if (!rst_n)
            mem[i] <= seed_rot(i);
         else if (we && (wa == AW'(i)))
            mem[i] <= wd;
      end
   end

   assign rd0 = mem[ra0];
   assign rd1 = mem[ra1];

endmodule

// File: rtl/slp_front.sv
module slp_front #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         in_v,
   input  logic [W-1:0] in_d,
   output logic         out_v,
   output logic [W-1:0] out_d
);

   logic [DEPTH-1:0] v;
   logic [W-1:0]     d [DEPTH];

   initial begin
      if (DEPTH < 1) $error("slp_front: DEPTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v <= '0;
         for (int i = 0; i < DEPTH; i++) d[i] <= '0;
      end else if (!hold) begin
         v[0] <= in_v;
         d[0] <= in_d;
         for (int i = 1; i < DEPTH; i++) begin
            v[i] <= v[i-1];
            d[i] <= d[i-1];
         end
      end
   end

   assign out_v = v[DEPTH-1];
   assign out_d = d[DEPTH-1];

   // R8
   front_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(v) && $stable(out_d)));

   // R3
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v && !hold) |=> v[0]);

endmodule

// File: rtl/slp_alu2.sv
module slp_alu2 #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_v,
   input  logic [1:0]        in_op,
   input  logic [AW-1:0]     in_dst,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              s4_v,
   output logic [AW-1:0]     s4_dst,
   output logic              s5_v,
   output logic [AW-1:0]     s5_dst,
   output logic [DATA_W-1:0] res
);

   localparam int NL   = DATA_W / LANE_W;
   localparam int HL   = NL / 2;
   localparam int HALF = HL * LANE_W;

   initial begin
      if (LANE_W < 1) $error("slp_alu2: LANE_W must be positive");
      if (DATA_W % (2 * LANE_W) != 0)
         $error("slp_alu2: DATA_W must hold an even number of lanes");
   end

   logic [1:0]        s4_op, s5_op;
   logic [DATA_W-1:0] s4_a, s4_b;
   logic [HALF-1:0]   lo_y, hi_y, s5_lo, s5_ahi, s5_bhi;

   generate
      for (genvar g = 0; g < NL; g++) begin : g_lane
         if (g < HL) begin : g_first
            slp_logic_lane #(.W(LANE_W)) lane_i (
               .op (s4_op),
               .a  (s4_a[g*LANE_W +: LANE_W]),
               .b  (s4_b[g*LANE_W +: LANE_W]),
               .y  (lo_y[g*LANE_W +: LANE_W])
            );
         end else begin : g_second
            slp_logic_lane #(.W(LANE_W)) lane_i (
               .op (s5_op),
               .a  (s5_ahi[(g-HL)*LANE_W +: LANE_W]),
               .b  (s5_bhi[(g-HL)*LANE_W +: LANE_W]),
               .y  (hi_y[(g-HL)*LANE_W +: LANE_W])
            );
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s4_v   <= 1'b0;
         s4_op  <= '0;
         s4_dst <= '0;
         s4_a   <= '0;
         s4_b   <= '0;
         s5_v   <= 1'b0;
         s5_op  <= '0;
         s5_dst <= '0;
         s5_lo  <= '0;
         s5_ahi <= '0;
         s5_bhi <= '0;
      end else begin
         s4_v   <= in_v;
         s4_op  <= in_op;
         s4_dst <= in_dst;
         s4_a   <= in_a;
         s4_b   <= in_b;
         s5_v   <= s4_v;
         s5_op  <= s4_op;
         s5_dst <= s4_dst;
         s5_lo  <= lo_y;
         s5_ahi <= s4_a[DATA_W-1 -: HALF];
         s5_bhi <= s4_b[DATA_W-1 -: HALF];
      end
   end

   assign res = {hi_y, s5_lo};

   // R3
   stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s4_v |=> s5_v);

   // R3
   alu_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_v |=> s4_v);

endmodule

// File: rtl/simd_logic_pipe.sv
module simd_logic_pipe #(
   parameter int                DATA_W     = 64,
   parameter int                NREGS      = 8,
   parameter int                LANE_W     = 8,
   parameter logic [DATA_W-1:0] RESET_SEED = 64'hF0E1_D2C3_B4A5_9687,
   parameter int                AW         = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   output logic              iss_ready,
   input  logic [1:0]        iss_op,
   input  logic [AW-1:0]     iss_dst,
   input  logic [AW-1:0]     iss_src,
   output logic              ret_valid,
   output logic [AW-1:0]     ret_dst,
   output logic [DATA_W-1:0] ret_data
);

   localparam int IW      = 2 + 2 * AW;
   localparam int FRONT_N = 4;

   initial begin
      if (NREGS < 2 || (1 << AW) != NREGS)
         $error("simd_logic_pipe: NREGS must be a power of two >= 2");
   end

   logic              s3_v, stall;
   logic [IW-1:0]     s3_d;
   logic [1:0]        s3_op;
   logic [AW-1:0]     s3_dst, s3_src;
   logic              s4_v, s5_v;
   logic [AW-1:0]     s4_dst, s5_dst;
   logic [DATA_W-1:0] res, rf_a, rf_b, op_a, op_b;

   slp_front #(.W(IW), .DEPTH(FRONT_N)) front_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (stall),
      .in_v  (iss_valid),
      .in_d  ({iss_op, iss_dst, iss_src}),
      .out_v (s3_v),
      .out_d (s3_d)
   );

   assign {s3_op, s3_dst, s3_src} = s3_d;

   // Interlock against the producer in the first ALU stage only;
   // a producer in the second stage is covered by forwarding.
   assign stall = s3_v && s4_v && ((s4_dst == s3_dst) || (s4_dst == s3_src));
   assign iss_ready = !stall;

   slp_regfile #(
      .DATA_W(DATA_W), .NREGS(NREGS), .AW(AW), .RESET_SEED(RESET_SEED)
   ) rf_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (s5_v),
      .wa    (s5_dst),
      .wd    (res),
      .ra0   (s3_dst),
      .rd0   (rf_a),
      .ra1   (s3_src),
      .rd1   (rf_b)
   );

   assign op_a = (s5_v && (s5_dst == s3_dst)) ? res : rf_a;
   assign op_b = (s5_v && (s5_dst == s3_src)) ? res : rf_b;

   slp_alu2 #(.DATA_W(DATA_W), .LANE_W(LANE_W), .AW(AW)) alu_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_v   (s3_v && !stall),
      .in_op  (s3_op),
      .in_dst (s3_dst),
      .in_a   (op_a),
      .in_b   (op_b),
      .s4_v   (s4_v),
      .s4_dst (s4_dst),
      .s5_v   (s5_v),
      .s5_dst (s5_dst),
      .res    (res)
   );

   assign ret_valid = s5_v;
   assign ret_dst   = s5_dst;
   assign ret_data  = res;

   // R6
   bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !s4_v);

   // R6
   single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   // R8
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_ready |=> ($stable(s3_d) && s3_v));

endmodule

// File: tb/simd_logic_pipe_tb_top.sv
module simd_logic_pipe_tb_top;

   localparam int          DW   = 64;
   localparam logic [63:0] SEED = 64'hF0E1_D2C3_B4A5_9687;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid = 1'b0;
   logic          iss_ready;
   logic [1:0]    iss_op = '0;
   logic [2:0]    iss_dst = '0, iss_src = '0;
   logic          ret_valid;
   logic [2:0]    ret_dst;
   logic [DW-1:0] ret_data;

   always #4 clk = ~clk;

   simd_logic_pipe dut_i (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_op(iss_op), .iss_dst(iss_dst), .iss_src(iss_src),
      .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_data(ret_data)
   );

   int cyc = 0;
   int nchk = 0, nfail = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [DW-1:0] rfm [8];
   int p_op[16], p_dst[16], p_src[16], p_gap[16];
   int acc[16], r_cyc[16], r_dst[16];
   logic [DW-1:0] r_dat[16];
   int rcnt = 0;

   always @(negedge clk) begin
      if (rst_n && ret_valid && rcnt < 16) begin
         r_cyc[rcnt] = cyc;
         r_dst[rcnt] = int'(ret_dst);
         r_dat[rcnt] = ret_data;
         rcnt++;
      end
   end

   function automatic logic [DW-1:0] rotl(input int sh);
      if (sh % DW == 0) return SEED;
      return (SEED << (sh % DW)) | (SEED >> (DW - (sh % DW)));
   endfunction

   function automatic logic [DW-1:0] fop(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
      case (op)
         0: return a & b;
         1: return a ^ b;
         2: return ~a & b;
         default: return a | b;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_ins(input int i, input int op, input int d, input int s, input int g);
      p_op[i] = op; p_dst[i] = d; p_src[i] = s; p_gap[i] = g;
   endtask

   // Issues n prepared instructions, then checks data, destination, order and retire cycle.
   task automatic run_seq(input int n, input string ctag);
      int exp_r, prev_r, t;
      logic [DW-1:0] ev;
      rcnt = 0;
      for (int i = 0; i < n; i++) begin
         repeat (p_gap[i]) @(negedge clk);
         iss_valid = 1'b1;
         iss_op  = 2'(p_op[i]);
         iss_dst = 3'(p_dst[i]);
         iss_src = 3'(p_src[i]);
         while (!iss_ready) @(negedge clk);
         acc[i] = cyc + 1;
         @(negedge clk);
         iss_valid = 1'b0;
      end
      t = 0;
      while (rcnt < n && t < 100) begin
         @(negedge clk);
         t++;
      end
      chk(rcnt == n, "R5 retire count", 64'(rcnt), 64'(n));
      prev_r = 0;
      for (int i = 0; i < n && i < rcnt; i++) begin
         ev = fop(p_op[i], rfm[p_dst[i]], rfm[p_src[i]]);
         rfm[p_dst[i]] = ev;
         chk(r_dat[i] === ev, "R2 R5 result data", r_dat[i], ev);
         chk(r_dst[i] == p_dst[i], "R9 R5 retire dst", 64'(r_dst[i]), 64'(p_dst[i]));
         exp_r = acc[i] + 5;
         if (i > 0) begin
            t = prev_r + 1 +
                ((p_dst[i-1] == p_dst[i] || p_dst[i-1] == p_src[i]) ? 1 : 0);
            if (t > exp_r) exp_r = t;
         end
         chk(r_cyc[i] == exp_r, ctag, 64'(r_cyc[i] - acc[0] + 1), 64'(exp_r - acc[0] + 1));
         prev_r = exp_r;
      end
   endtask

   task automatic t_reset;
      chk(iss_ready === 1'b1, "R1 iss_ready after reset", 64'(iss_ready), 64'd1);
      chk(ret_valid === 1'b0, "R1 ret_valid after reset", 64'(ret_valid), 64'd0);
   endtask

   task automatic t_reset_vals;
      for (int i = 0; i < 8; i++) set_ins(i, 3, i, i, 0);
      run_seq(8, "R4 throughput on eight OR self ops");
      for (int i = 0; i < 8 && i < rcnt; i++)
         chk(r_dat[i] === rotl(8 * i), "R1 reset contents", r_dat[i], rotl(8 * i));
   endtask

   task automatic t_indep;
      set_ins(0, 0, 0, 1, 0);
      set_ins(1, 1, 2, 3, 0);
      set_ins(2, 2, 4, 5, 0);
      set_ins(3, 3, 6, 7, 0);
      run_seq(4, "R4 independent cycles 6..9");
      chk(r_cyc[3] - acc[0] + 1 == 9, "R4 fourth retire on cycle 9", 64'(r_cyc[3] - acc[0] + 1), 64'd9);
   endtask

   task automatic t_chain;
      set_ins(0, 0, 0, 1, 0);
      set_ins(1, 1, 2, 3, 0);
      set_ins(2, 2, 2, 4, 0);
      set_ins(3, 3, 2, 5, 0);
      run_seq(4, "R6 dependent chain cycles");
      chk(r_cyc[3] - acc[0] + 1 == 11, "R6 chain finishes on cycle 11", 64'(r_cyc[3] - acc[0] + 1), 64'd11);
   endtask

   task automatic t_src_dep;
      set_ins(0, 1, 1, 6, 0);
      set_ins(1, 0, 3, 1, 0);
      run_seq(2, "R6 dependence through src");
      chk(r_cyc[1] - r_cyc[0] == 2, "R6 src dependence one bubble", 64'(r_cyc[1] - r_cyc[0]), 64'd2);
   endtask

   task automatic t_dist2;
      set_ins(0, 1, 4, 5, 0);
      set_ins(1, 3, 6, 7, 0);
      set_ins(2, 0, 0, 4, 0);
      set_ins(3, 2, 6, 6, 0);
      run_seq(4, "R7 distance-two dependence");
      chk(r_cyc[3] - r_cyc[0] == 3, "R7 no bubble at distance two", 64'(r_cyc[3] - r_cyc[0]), 64'd3);
   endtask

   task automatic t_ready;
      set_ins(0, 1, 5, 2, 0);
      set_ins(1, 3, 7, 5, 0);
      set_ins(2, 0, 0, 1, 0);
      set_ins(3, 1, 2, 3, 0);
      set_ins(4, 2, 4, 6, 0);
      set_ins(5, 3, 1, 3, 0);
      run_seq(6, "R8 stall holds younger instructions");
      chk(acc[4] - acc[0] == 4, "R8 accepts before stall", 64'(acc[4] - acc[0]), 64'd4);
      chk(acc[5] - acc[0] == 6, "R8 ready low during stall", 64'(acc[5] - acc[0]), 64'd6);
   endtask

   task automatic t_gaps;
      set_ins(0, 2, 3, 0, 0);
      set_ins(1, 1, 3, 7, 2);
      set_ins(2, 0, 5, 3, 1);
      run_seq(3, "R3 latency with idle gaps");
      for (int i = 0; i < 3; i++)
         chk(r_cyc[i] - acc[i] == 5, "R3 five edges from accept", 64'(r_cyc[i] - acc[i]), 64'd5);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) rfm[i] = rotl(8 * i);
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_reset_vals;
      t_indep;
      t_chain;
      t_src_dep;
      t_dist2;
      t_ready;
      t_gaps;
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      wait (cyc >= 20000);
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule